// File: doc/BRIEF.md
# Partitioned SIMD Lane Adder

This block adds two operand vectors as sets of independent lanes of one size. A lane-size select divides the vector into lanes of 8, 16, 32 or 64 bits. No carry ever passes from one lane into the next. An operation select picks one of three arithmetic behaviours, applied the same way to every lane in the same issue: plain modular addition, signed saturation, or unsigned saturation. A saturating lane clamps on its own and raises its own flag.

The block has two widths. In wide mode it works on the full 128-bit vector. In packed mode it works only on the low 32 bits, as four bytes, two halfwords or one word. Results and flags are registered, so each issue appears one clock after its valid strobe.

Top module: `simd_lane_adder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after the cycle in which `in_valid` was high.
- R2: `result` and `sat_flags` load only when an issue is accepted. Between issues they hold their previous values.
- R3: `lane_sel` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits k*w to k*w+w-1. The carry out of a lane never affects any other lane.
- R4: When `op_sel` is 0 (and also for the spare code 3), each lane holds the low w bits of its sum, and no flag is set.
- R5: When `op_sel` is 1, the lanes are two's-complement. A lane that overflows upward returns 2^(w-1)-1. A lane that overflows downward returns -2^(w-1). Either way the lane's flag is set.
- R6: When `op_sel` is 2, the lanes are unsigned. A lane whose sum carries out of w bits returns all ones and sets its flag.
- R7: When `wide_mode` is 0, only bits 31:0 take part and `result[127:32]` is zero. In this mode a `lane_sel` of 3 acts as 32-bit lanes.
- R8: Bit k of `sat_flags` belongs to lane k. Flag bits at or above the number of lanes in use are zero.
- R9: After a synchronous reset, `out_valid`, `result` and `sat_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| wide_mode | input | 1 | 1: 128-bit vector, 0: 32-bit packed |
| lane_sel | input | 2 | Lane width code |
| op_sel | input | 2 | 0 wrap, 1 signed saturate, 2 unsigned saturate |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Lane-wise sum |
| sat_flags | output | 16 | Per-lane saturation flags |

## Verification
Each wrong internal state shows up in the result of the same issue, one cycle after the strobe. A carry that leaks across a lane boundary changes the low bit of the next lane, which becomes visible when all-ones lanes are added to ones. A wrong lane-end decode puts the saturation clamp or its flag on the wrong byte or the wrong flag bit. A dropped upper mask in packed mode leaves nonzero bits above bit 31. The reference model is compared against the outputs in every cycle, so each of these faults fails in the first cycle after the offending issue.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_WRAP = 2'd0,
    OP_SSAT = 2'd1,
    OP_USAT = 2'd2,
    OP_RSVD = 2'd3
  } simd_op_e;
endpackage

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl #(
  parameter int NB = 16,
  parameter int PB = 4
) (
  input  logic          wide_mode,
  input  logic [1:0]    lane_sel,
  output logic [1:0]    eff_log,
  output logic [NB-1:0] start_mask,
  output logic [NB-1:0] end_mask
);
  localparam logic [1:0] PLOG = 2'($clog2(PB));

  always_comb begin
    eff_log = (!wide_mode && lane_sel > PLOG) ? PLOG : lane_sel;
    for (int i = 0; i < NB; i++) begin
      start_mask[i] = ((i & ((1 << eff_log) - 1)) == 0) || (!wide_mode && i >= PB);
    end
    for (int i = 0; i < NB - 1; i++) begin
      end_mask[i] = start_mask[i+1];
    end
    end_mask[NB-1] = 1'b1;
  end
endmodule

// File: rtl/simd_byte_slice.sv
module simd_byte_slice (
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       cin,
  output logic [7:0] sum,
  output logic       cout,
  output logic       ovf
);
  always_comb begin
    {cout, sum} = {1'b0, a} + {1'b0, b} + {8'd0, cin};
    ovf = (a[7] == b[7]) && (sum[7] != a[7]);
  end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int VEC_W  = 128,
  parameter int PACK_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             wide_mode,
  input  logic [1:0]       lane_sel,
  input  logic [1:0]       op_sel,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic [VEC_W/8-1:0] sat_flags
);
  import simd_pkg::*;

  localparam int NB = VEC_W / 8;
  localparam int PB = PACK_W / 8;

  logic [VEC_W-1:0] a_m, b_m, sum_w, res_d;
  logic [NB-1:0]    start_mask, end_mask, cin, cout, ovf;
  logic [NB-1:0]    l_carry, l_ovf, l_neg, l_hit;
  logic [NB-1:0]    flags_d;
  logic [1:0]       eff_log;
  simd_op_e         op;

  assign op = simd_op_e'(op_sel);

  always_comb begin
    a_m = opa;
    b_m = opb;
    if (!wide_mode) begin
      a_m[VEC_W-1:PACK_W] = '0;
      b_m[VEC_W-1:PACK_W] = '0;
    end
  end

  simd_lane_ctrl #(.NB(NB), .PB(PB)) u_ctrl (
    .wide_mode (wide_mode),
    .lane_sel  (lane_sel),
    .eff_log   (eff_log),
    .start_mask(start_mask),
    .end_mask  (end_mask)
  );

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_slice
      if (g == 0) begin : g_first
        assign cin[g] = 1'b0;
      end else begin : g_rest
        assign cin[g] = start_mask[g] ? 1'b0 : cout[g-1];
      end
      simd_byte_slice u_slice (
        .a   (a_m[g*8 +: 8]),
        .b   (b_m[g*8 +: 8]),
        .cin (cin[g]),
        .sum (sum_w[g*8 +: 8]),
        .cout(cout[g]),
        .ovf (ovf[g])
      );
    end
  endgenerate

  // Spread each lane's end-byte status back over all its bytes.
  always_comb begin
    for (int i = NB - 1; i >= 0; i--) begin
      if (end_mask[i] || i == NB - 1) begin
        l_carry[i] = cout[i];
        l_ovf[i]   = ovf[i];
        l_neg[i]   = a_m[i*8 + 7];
      end else begin
        l_carry[i] = l_carry[i+1];
        l_ovf[i]   = l_ovf[i+1];
        l_neg[i]   = l_neg[i+1];
      end
    end
  end

  always_comb begin
    flags_d = '0;
    for (int i = 0; i < NB; i++) begin
      l_hit[i] = (op == OP_SSAT && l_ovf[i]) || (op == OP_USAT && l_carry[i]);
      if (!l_hit[i]) begin
        res_d[i*8 +: 8] = sum_w[i*8 +: 8];
      end else if (op == OP_USAT) begin
        res_d[i*8 +: 8] = 8'hFF;
      end else if (l_neg[i]) begin
        res_d[i*8 +: 8] = end_mask[i] ? 8'h80 : 8'h00;
      end else begin
        res_d[i*8 +: 8] = end_mask[i] ? 8'h7F : 8'hFF;
      end
      if (end_mask[i] && l_hit[i]) begin
        flags_d[i >> eff_log] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_d;
        sat_flags <= flags_d;
      end
    end
  end
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
  parameter int VEC_W  = 128,
  parameter int PACK_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             wide_mode,
  input logic [1:0]       lane_sel,
  input logic [1:0]       op_sel,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic [VEC_W/8-1:0] sat_flags
);
  localparam int PB = PACK_W / 8;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(sat_flags))); // R2
  AST_WRAP_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == 2'd0 || op_sel == 2'd3)) |=> (sat_flags == '0)); // R4
  AST_PACKED_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_mode) |=> (result[VEC_W-1:PACK_W] == '0 && sat_flags[VEC_W/8-1:PB] == '0)); // R7
  AST_FLAG_RANGE_64: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_mode && lane_sel == 2'd3) |=> (sat_flags[VEC_W/8-1:2] == '0)); // R8
endmodule

bind simd_lane_adder simd_lane_adder_chk #(.VEC_W(VEC_W), .PACK_W(PACK_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .wide_mode(wide_mode),
  .lane_sel (lane_sel),
  .op_sel   (op_sel),
  .out_valid(out_valid),
  .result   (result),
  .sat_flags(sat_flags)
);

// File: tb/sim_simd_lane_adder.sv
`timescale 1ns/1ps
module sim_simd_lane_adder;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         wide_mode = 1'b0;
  logic [1:0]   lane_sel = 2'd0;
  logic [1:0]   op_sel = 2'd0;
  logic [127:0] opa = '0, opb = '0;
  logic         out_valid;
  logic [127:0] result;
  logic [15:0]  sat_flags;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_lane_adder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
    .lane_sel(lane_sel), .op_sel(op_sel), .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
  );

  // Behavioural reference: lane by lane using wide integers.
  function automatic void ref_add(input logic [127:0] a, input logic [127:0] b,
                                  input logic wide, input logic [1:0] ls,
                                  input logic [1:0] op,
                                  output logic [127:0] r, output logic [15:0] f);
    int w, nl;
    logic [64:0] ua, ub, us, mask, lv;
    logic [127:0] t;
    bit carry, ov;
    w = 8 << ls;
    if (!wide && w > 32) w = 32;
    nl = (wide ? 128 : 32) / w;
    mask = (65'd1 << w) - 65'd1;
    r = '0;
    f = '0;
    for (int k = 0; k < nl; k++) begin
      ua = 65'(a >> (k * w)) & mask;
      ub = 65'(b >> (k * w)) & mask;
      us = ua + ub;
      carry = us[w];
      ov = (ua[w-1] == ub[w-1]) && (us[w-1] != ua[w-1]);
      lv = us & mask;
      if (op == 2'd1 && ov) begin
        lv = ua[w-1] ? (65'd1 << (w - 1)) : (mask >> 1);
        f[k] = 1'b1;
      end else if (op == 2'd2 && carry) begin
        lv = mask;
        f[k] = 1'b1;
      end
      t = '0;
      t[64:0] = lv & mask;
      r = r | (t << (k * w));
    end
  endfunction

  logic         exp_v;
  logic [127:0] exp_r, m_r;
  logic [15:0]  exp_f, m_f;

  always @(posedge clk) begin
    if (rst) begin
      exp_v <= 1'b0;
      exp_r <= '0;
      exp_f <= '0;
    end else begin
      exp_v <= in_valid;
      if (in_valid) begin
        ref_add(opa, opb, wide_mode, lane_sel, op_sel, m_r, m_f);
        exp_r <= m_r;
        exp_f <= m_f;
      end
    end
  end

  logic [1:0] last_op = 2'd0;
  always @(posedge clk) if (in_valid) last_op <= op_sel;

  // Every-cycle comparison against the reference model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (out_valid !== exp_v) begin
        fails++;
        $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, exp_v);
      end
      checks++;
      if (result !== exp_r || sat_flags !== exp_f) begin
        fails++;
        $display("FAIL %s result %h flags %h expected %h flags %h",
                 (last_op == 2'd1) ? "R5" : (last_op == 2'd2) ? "R6" : "R4",
                 result, sat_flags, exp_r, exp_f);
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] er, input logic [15:0] ef);
    checks++;
    if (result !== er || sat_flags !== ef) begin
      fails++;
      $display("FAIL %s result %h flags %h expected %h flags %h", tag, result, sat_flags, er, ef);
    end
  endtask

  task automatic issue(input logic w, input logic [1:0] ls, input logic [1:0] op,
                       input logic [127:0] a, input logic [127:0] b);
    wide_mode = w; lane_sel = ls; op_sel = op; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R9
    if (out_valid !== 1'b0 || result !== '0 || sat_flags !== '0) begin
      fails++;
      $display("FAIL R9 reset state %b %h %h expected 0 0 0", out_valid, result, sat_flags);
    end
    rst = 1'b0;
    @(negedge clk);

    issue(1'b0, 2'd0, 2'd0, 128'hFF01_7F80, 128'h0101_0180);
    chk("R3 R4 packed bytes wrap", 128'h0002_8000, 16'h0000);
    issue(1'b0, 2'd0, 2'd2, 128'hFF01_7F80, 128'h0101_0180);
    chk("R6 packed bytes unsigned", 128'hFF02_80FF, 16'h0009);
    issue(1'b0, 2'd0, 2'd1, 128'hFF01_7F80, 128'h0101_0180);
    chk("R5 packed bytes signed", 128'h0002_7F80, 16'h0003);
    issue(1'b0, 2'd3, 2'd0, {96'hFFFF, 32'hFFFF_FFFF}, {96'h1, 32'h0000_0002});
    chk("R7 packed upper ignored", 128'h0000_0001, 16'h0000);
    issue(1'b1, 2'd1, 2'd0, {8{16'hFFFF}}, {8{16'h0001}});
    chk("R3 halfword carry cut", '0, 16'h0000);
    issue(1'b1, 2'd3, 2'd2, {64'hFFFF_FFFF_FFFF_FFFF, 64'h1}, {64'h1, 64'h2});
    chk("R8 64-bit unsigned flag", {64'hFFFF_FFFF_FFFF_FFFF, 64'h3}, 16'h0002);
    issue(1'b1, 2'd2, 2'd1, {32'h7FFF_FFFF, 32'h8000_0000, 32'h1, 32'h2},
                            {32'h0000_0001, 32'hFFFF_FFFF, 32'h1, 32'h3});
    chk("R5 word signed clamps", {32'h7FFF_FFFF, 32'h8000_0000, 32'h2, 32'h5}, 16'h000C);
    issue(1'b1, 2'd0, 2'd3, {16{8'hF0}}, {16{8'h20}});
    chk("R4 spare op wraps", {16{8'h10}}, 16'h0000);
    wide_mode = 1'b0; opa = '1; opb = '1; op_sel = 2'd2;
    @(negedge clk);
    chk("R2 hold when idle", {16{8'h10}}, 16'h0000);

    for (int n = 0; n < 300; n++) begin
      logic [127:0] a, b;
      a = {$urandom(), $urandom(), $urandom(), $urandom()};
      b = {$urandom(), $urandom(), $urandom(), $urandom()};
      if (n % 4 == 0) a = a | {4{32'h7F7F_7F7F}};
      wide_mode = 1'($urandom());
      lane_sel = 2'($urandom());
      op_sel = 2'($urandom());
      opa = a;
      opb = b;
      in_valid = 1'($urandom() % 3 != 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule